// File: doc/BRIEF.md
# Cascadable LCD Column Driver Core

This block is the digital part of a 64-column dot-matrix LCD column driver. A display controller streams one row of pixel data as 4-bit nibbles, each taken on a falling edge of a data shift clock. Several drivers share the nibble bus and the strobes. A chained enable decides which driver in the chain currently takes nibbles. When a driver holds all sixteen nibbles of its own row, it raises its enable output so that the next driver in the chain takes over.

A falling edge on the line latch pulse copies the assembled row into an output latch. The same edge releases the enable output, so each driver is free for the next line. Every latched column is then turned into a 2-bit drive-level code from its bit and the AC frame signal. The analog stage uses this code to pick one of four LCD rails. All strobes and inputs are brought into one system clock domain through two-flop synchronisers. Each falling edge becomes a single-cycle pulse.

Top module: `lcd_column_core`

## Requirements
- R1: After reset the enable output is low, the output latch holds all zeros, and with the frame input low every column code is 1.
- R2: A nibble is taken on a falling edge of the shift clock only while the driver is armed. Nibble bit 0 lands on the lowest-numbered column of its group of four. After sixteen transfers the first nibble sits in columns 0 to 3 and the last nibble sits in columns 60 to 63.
- R3: The enable output rises on the shift-clock falling edge that completes the sixteenth transfer, and not before. After that, further shift-clock edges leave the row unchanged.
- R4: A latch-pulse falling edge copies the current row into the output latch. At no other time does the latched row change.
- R5: A latch-pulse falling edge clears the enable output and the transfer count. A row begun after it needs sixteen new transfers.
- R6: The driver arms on an enable-clock falling edge at which the sampled enable input is high and was low at the previous enable-clock falling edge. While the driver is not armed, shift-clock edges do not change the row.
- R7: Each column's 2-bit code follows {latched bit, frame}: 00 gives 1, 01 gives 2, 10 gives 0, 11 gives 3.
- R8: The enable input may be held high during the latch pulse high phase, with an enable-clock edge inside it. The driver is then armed for the line that follows that latch edge.
- R9: Each strobe falling edge acts once, however long the strobe then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shclk_in | input | 1 | Data shift clock, falling edge active |
| lp_in | input | 1 | Line latch pulse, falling edge active |
| ecl_in | input | 1 | Enable clock, falling edge active |
| en_in | input | 1 | Chain enable input, active high |
| fr_in | input | 1 | AC frame polarity |
| din | input | 4 | Display data nibble |
| en_out | output | 1 | Chain enable output to next driver |
| seg_lvl | output | 128 | Two-bit drive code per column, column i at bits 2i+1:2i |

## Verification
A wrong transfer count shows at the enable output on the very nibble where it should, or should not, have risen. That is checked after every nibble. A wrong shift order or a gated shift shows up only when the row reaches the latch. So every line ends in a latch pulse, and all 128 code bits are compared against a model row at once. An arming fault shows as a whole row that is stale or shifted by one line. Frame polarity is toggled without a latch pulse, to show that the codes follow the frame input while the latched row stays put.

// File: rtl/lcd_column_core.sv
module lcd_column_core #(
  parameter int COLS = 64,
  parameter int NIB  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shclk_in,
  input  logic                lp_in,
  input  logic                ecl_in,
  input  logic                en_in,
  input  logic                fr_in,
  input  logic [NIB-1:0]      din,
  output logic                en_out,
  output logic [2*COLS-1:0]   seg_lvl
);
  localparam int STAGES = COLS / NIB;
  localparam int CW     = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAGES - 1);

  logic [2:0]      xs_q, lp_q, ec_q;
  logic [1:0]      en_q, fr_q;
  logic [NIB-1:0]  d_q1, d_q2;
  logic            xs_fe, lp_fe, ec_fe, arm;
  logic            active, en_prev;
  logic [CW-1:0]   cnt;
  logic [COLS-1:0] sr, latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_q <= '0; lp_q <= '0; ec_q <= '0;
      en_q <= '0; fr_q <= '0;
      d_q1 <= '0; d_q2 <= '0;
    end else begin
      xs_q <= {xs_q[1:0], shclk_in};
      lp_q <= {lp_q[1:0], lp_in};
      ec_q <= {ec_q[1:0], ecl_in};
      en_q <= {en_q[0], en_in};
      fr_q <= {fr_q[0], fr_in};
      d_q1 <= din;
      d_q2 <= d_q1;
    end
  end

  assign xs_fe = xs_q[2] & ~xs_q[1];
  assign lp_fe = lp_q[2] & ~lp_q[1];
  assign ec_fe = ec_q[2] & ~ec_q[1];
  assign arm   = ec_fe & en_q[1] & ~en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev <= 1'b0;
    end else if (ec_fe) begin
      en_prev <= en_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      en_out <= 1'b0;
      sr     <= '0;
      latch  <= '0;
    end else if (lp_fe) begin
      latch  <= sr;
      cnt    <= '0;
      en_out <= 1'b0;
      if (arm) active <= 1'b1;
    end else if (arm) begin
      active <= 1'b1;
    end else if (xs_fe && active) begin
      sr <= {d_q2, sr[COLS-1:NIB]};
      if (cnt == LAST) begin
        cnt    <= '0;
        active <= 1'b0;
        en_out <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < COLS; i++) begin : g_col
    assign seg_lvl[2*i +: 2] = latch[i] ? (fr_q[1] ? 2'd3 : 2'd0)
                                        : (fr_q[1] ? 2'd2 : 2'd1);
  end
endmodule

// File: rtl/lcd_column_chk.sv
module lcd_column_chk #(
  parameter int COLS = 64,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xs_fe,
  input logic            lp_fe,
  input logic            arm,
  input logic            active,
  input logic            en_out,
  input logic [CW-1:0]   cnt,
  input logic [COLS-1:0] sr,
  input logic [COLS-1:0] latch
);
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_fe |=> $stable(latch));

  p_enout_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fe |=> !en_out && cnt == '0);

  p_enout_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_fe && !en_out) ##1 en_out |-> $past(xs_fe) && $past(active));

  p_idle_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || !xs_fe || arm || lp_fe) |=> $stable(sr));

  p_full_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_out) |-> !active);
endmodule

bind lcd_column_core lcd_column_chk #(.COLS(COLS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xs_fe(xs_fe), .lp_fe(lp_fe), .arm(arm),
  .active(active), .en_out(en_out), .cnt(cnt), .sr(sr), .latch(latch)
);

// File: tb/sim_lcd_column_core.sv
module sim_lcd_column_core;
  localparam int COLS = 64;
  localparam int NIB  = 4;

  logic clk = 0, rst_n = 0;
  logic shclk_in = 0, lp_in = 0, ecl_in = 0, en_in = 0, fr_in = 0;
  logic [NIB-1:0] din = '0;
  logic en_out;
  logic [2*COLS-1:0] seg_lvl;

  int tests = 0, fails = 0;
  logic [COLS-1:0] m_sr = '0, m_latch = '0;
  logic m_active = 0, m_enout = 0, m_enprev = 0, m_fr = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  lcd_column_core #(.COLS(COLS), .NIB(NIB)) u0 (
    .clk(clk), .rst_n(rst_n), .shclk_in(shclk_in), .lp_in(lp_in),
    .ecl_in(ecl_in), .en_in(en_in), .fr_in(fr_in), .din(din),
    .en_out(en_out), .seg_lvl(seg_lvl));

  function automatic logic [2*COLS-1:0] exp_seg(logic [COLS-1:0] row, logic fr);
    logic [2*COLS-1:0] v;
    for (int i = 0; i < COLS; i++)
      v[2*i +: 2] = row[i] ? (fr ? 2'd3 : 2'd0) : (fr ? 2'd2 : 2'd1);
    return v;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_en(string req);
    tests++;
    if (en_out !== m_enout) begin
      fails++;
      $display("FAIL %s en_out actual=%b expected=%b", req, en_out, m_enout);
    end
  endtask

  task automatic chk_seg(string req);
    logic [2*COLS-1:0] e;
    e = exp_seg(m_latch, m_fr);
    tests++;
    if (seg_lvl !== e) begin
      fails++;
      $display("FAIL %s seg_lvl actual=%h expected=%h", req, seg_lvl, e);
    end
  endtask

  task automatic shift_nib(logic [NIB-1:0] n, int low_hold);
    din = n; shclk_in = 1; wait_clk(4);
    shclk_in = 0; wait_clk(low_hold);
    if (m_active) begin
      m_sr = {n, m_sr[COLS-1:NIB]};
      m_cnt++;
      if (m_cnt == COLS / NIB) begin m_cnt = 0; m_active = 0; m_enout = 1; end
    end
  endtask

  task automatic ecl_pulse(logic en);
    en_in = en; wait_clk(4);
    ecl_in = 1; wait_clk(4); ecl_in = 0; wait_clk(4);
    if (en && !m_enprev) m_active = 1;
    m_enprev = en;
  endtask

  task automatic do_latch();
    m_latch = m_sr; m_cnt = 0; m_enout = 0;
  endtask

  // R8: enable held high through the latch pulse, enable-clock edge inside it
  task automatic start_line();
    lp_in = 1; en_in = 1; wait_clk(4);
    ecl_in = 1; wait_clk(4); ecl_in = 0; wait_clk(4);
    if (!m_enprev) m_active = 1;
    m_enprev = 1;
    lp_in = 0; en_in = 0; wait_clk(5);
    do_latch();
    ecl_pulse(0);
  endtask

  task automatic lp_only();
    lp_in = 1; wait_clk(4); lp_in = 0; wait_clk(5);
    do_latch();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b));
    wait_clk(3); rst_n = 1; wait_clk(3);
    chk_en("R1"); chk_seg("R1");

    // R6: not armed, shifts ignored
    for (int i = 0; i < 5; i++) shift_nib(4'hF, 4);
    lp_only(); chk_seg("R6"); chk_en("R6");

    // R2 R3: directed row, nibble k = k
    start_line();
    for (int k = 0; k < 16; k++) begin
      shift_nib(4'(k), 4);
      chk_en(k == 15 ? "R3" : "R2");
    end
    shift_nib(4'h5, 4); shift_nib(4'hA, 4); chk_en("R3");
    chk_seg("R4");
    lp_only(); chk_seg("R2"); chk_en("R5");
    // R7: all four codes seen, frame toggles without a latch edge
    fr_in = 1; m_fr = 1; wait_clk(4); chk_seg("R7");
    fr_in = 0; m_fr = 0; wait_clk(4); chk_seg("R7");

    // R9: long low shift-clock phase counts once
    start_line();
    shift_nib(4'h9, 40);
    for (int k = 0; k < 14; k++) begin shift_nib(4'h3, 4); chk_en("R9"); end
    shift_nib(4'hC, 4); chk_en("R9");

    // R5: partial line then new line needs sixteen transfers
    start_line(); chk_en("R5");
    for (int k = 0; k < 10; k++) shift_nib(4'(k + 3), 4);
    lp_only(); chk_seg("R4");

    // R6: enable held high with no low sample between does not re-arm
    ecl_pulse(1); ecl_pulse(1);
    for (int k = 0; k < 16; k++) shift_nib(4'h6, 4);
    chk_en("R6");
    ecl_pulse(1);
    for (int k = 0; k < 4; k++) shift_nib(4'h1, 4);
    lp_only(); chk_seg("R6"); chk_en("R5");
    ecl_pulse(0);

    for (int ln = 0; ln < 20; ln++) begin
      int n;
      start_line();
      n = $urandom_range(20, 4);
      for (int k = 0; k < n; k++) begin
        shift_nib(4'($urandom), 4);
        chk_en("R3");
      end
      fr_in = 1'($urandom); m_fr = fr_in; wait_clk(4);
      chk_seg("R4");
      lp_only(); chk_seg("R7");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule